// File: doc/BRIEF.md
# Atomic Byte Compare-and-Swap Unit

This unit executes the byte-wide compare-and-swap operation of a load/store pipeline. It receives a 32-bit instruction word together with the values of the three registers that word names: the base address register, the compare/result register and the store-value register. The stack pointer value comes on its own input. When the word matches the expected encoding, the unit runs a locked read-modify-write sequence on a simple byte memory port. It reads the addressed byte and compares it with the low byte of the compare register. It stores the low byte of the store-value register only when the two bytes are equal. It then writes the old byte, zero-extended, back to the compare register.

The unit also produces per-instruction attributes for the rest of the pipeline: an acquire ordering flag, a release ordering flag, a tag-check flag and a one-cycle reuse hint. A word that does not match the encoding is reported as undefined and starts nothing. A misaligned stack-pointer base raises an alignment fault before any memory access. A bus abort on either access ends the operation with no register update. While an operation is in flight the unit is busy and accepts no new word.

Top module: `bcas_unit`

## Requirements
- R1: A word is claimed only when bits [31:30]=00, bits [29:23]=0010001, bit 21=1 and bits [14:10]=11111. Any other word presented while idle pulses `undef_insn` for one cycle, one cycle after acceptance. It leaves `busy` low and issues no memory request.
- R2: The variant bits are bit 22 (L) and bit 15 (O). `acq_order` is high only when L=1 and the store-value register number (bits [4:0]) is not 31. `rel_order` equals O. Both are valid from the cycle after acceptance until `done`.
- R3: The compare register number is bits [20:16] and the base register number is bits [9:5]. When the base number is 31, the address is `sp_val` and `tag_check` is low. Otherwise the address is `base_val` and `tag_check` is high.
- R4: When the base number is 31 and the low 4 bits of `sp_val` are not zero, the unit raises `align_fault` together with `done`. It issues no memory request and no register write-back.
- R5: The unit reads one byte at the computed address. If that byte equals bits [7:0] of `cmp_val`, it writes bits [7:0] of `new_val` to the same address. Upper compare bits are ignored.
- R6: When the bytes differ, no memory write is issued. This includes the case where the compare and store-value register numbers are the same.
- R7: `mem_lock` is high during every memory request and stays high without a gap from the read request until the write completes or the compare-fail decision is made.
- R8: On normal completion, `wb_en` and `done` are high for one cycle. `wb_idx` is the compare register number and `wb_data` is the byte read, zero-extended to 32 bits. This happens whether the compare succeeded or failed.
- R9: An abort on the read or the write raises `abort_fault` together with `done`, with `wb_en` low, so the compare register keeps its value. An aborted write does not change memory.
- R10: When the compare and store-value register numbers are equal and O=0, `reuse_hint` pulses for one cycle, one cycle after acceptance. Otherwise it stays low.
- R11: `busy` is high from the cycle after acceptance through the `done` cycle. `insn_valid` has no effect while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | Instruction word presented |
| insn_word | input | 32 | Instruction word |
| cmp_val | input | REG_W | Value of the compare register |
| new_val | input | REG_W | Value of the store-value register |
| base_val | input | ADDR_W | Value of the base register |
| sp_val | input | ADDR_W | Stack pointer value |
| busy | output | 1 | Operation in flight |
| done | output | 1 | One-cycle completion pulse |
| undef_insn | output | 1 | Unclaimed-word pulse |
| align_fault | output | 1 | Stack-pointer alignment fault, with done |
| abort_fault | output | 1 | Memory abort fault, with done |
| acq_order | output | 1 | Acquire ordering flag |
| rel_order | output | 1 | Release ordering flag |
| tag_check | output | 1 | Tag-check flag |
| reuse_hint | output | 1 | Reuse hint pulse |
| wb_en | output | 1 | Compare register write-back strobe |
| wb_idx | output | 5 | Write-back register number |
| wb_data | output | REG_W | Write-back data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_lock | output | 1 | Bus lock |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_ack | input | 1 | Request accepted and completed |
| mem_abort | input | 1 | Access aborted, valid with mem_ack |
| mem_rdata | input | 8 | Read byte, valid with mem_ack |

## Verification
Several properties are checked on every cycle. The lock must cover every request and must not drop before completion. No write may follow a failed compare. A fault must never coincide with a write-back. An alignment fault must come straight from idle. The address must stay stable during an operation, and done, undefined and reuse-hint pulses must last one cycle. Only the bench scenarios can show the end results: the actual bytes left in memory, the zero-extended value returned, the decode of every variant and register-number rule, abort handling on each access, and that a word presented while busy is ignored.

// File: rtl/bcas_pkg.sv
package bcas_pkg;
  localparam int INSN_W = 32;
  localparam int RIDX_W = 5;
  localparam int BYTE_W = 8;
  localparam logic [RIDX_W-1:0] ZR_IDX = 5'd31;
  localparam logic [1:0] SIZE_BYTE = 2'b00;
  localparam logic [6:0] OPC_CAS   = 7'b0010001;
  localparam logic [4:0] PAIR_ONES = 5'b11111;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_CMP   = 3'd2,
    ST_WRITE = 3'd3,
    ST_WB    = 3'd4,
    ST_FAULT = 3'd5
  } bcas_state_e;

  typedef struct packed {
    logic              claim;
    logic              acq;
    logic              rel;
    logic              tagchk;
    logic              hint;
    logic [RIDX_W-1:0] rs;
    logic [RIDX_W-1:0] rn;
    logic [RIDX_W-1:0] rt;
  } bcas_dec_t;
endpackage

// File: rtl/bcas_decode.sv
module bcas_decode
  import bcas_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output bcas_dec_t         dec
);
  logic              l_bit;
  logic              o_bit;
  logic [RIDX_W-1:0] rs_f;
  logic [RIDX_W-1:0] rn_f;
  logic [RIDX_W-1:0] rt_f;

  always_comb begin
    l_bit = insn[22];
    o_bit = insn[15];
    rs_f  = insn[20:16];
    rn_f  = insn[9:5];
    rt_f  = insn[4:0];

    dec.claim  = (insn[31:30] == SIZE_BYTE) &&
                 (insn[29:23] == OPC_CAS)   &&
                 insn[21]                   &&
                 (insn[14:10] == PAIR_ONES);
    dec.acq    = l_bit && (rt_f != ZR_IDX);
    dec.rel    = o_bit;
    dec.tagchk = (rn_f != ZR_IDX);
    dec.hint   = (rs_f == rt_f) && !o_bit;
    dec.rs     = rs_f;
    dec.rn     = rn_f;
    dec.rt     = rt_f;
  end
endmodule

// File: rtl/bcas_datapath.sv
module bcas_datapath
  import bcas_pkg::*;
#(
  parameter int ADDR_W        = 64,
  parameter int REG_W         = 32,
  parameter int SP_ALIGN_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              rd_en,
  input  bcas_state_e       state,
  input  bcas_dec_t         dec,
  input  logic [REG_W-1:0]  cmp_val,
  input  logic [REG_W-1:0]  new_val,
  input  logic [ADDR_W-1:0] base_val,
  input  logic [ADDR_W-1:0] sp_val,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              sp_misaligned,
  output logic              cmp_equal,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic [REG_W-1:0]  wb_data,
  output logic [RIDX_W-1:0] wb_idx,
  output logic              acq,
  output logic              rel,
  output logic              tagchk
);
  localparam int PAD_W = REG_W - BYTE_W;

  logic              use_sp;
  logic [ADDR_W-1:0] addr_d;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] cmpb_q;
  logic [BYTE_W-1:0] newb_q;
  logic [BYTE_W-1:0] old_q;
  logic [RIDX_W-1:0] rs_q;
  logic              acq_q;
  logic              rel_q;
  logic              tag_q;

  always_comb begin
    use_sp = (dec.rn == ZR_IDX);
    addr_d = use_sp ? sp_val : base_val;
  end

  generate
    if (SP_ALIGN_LOG2 == 0) begin : g_noalign
      assign sp_misaligned = 1'b0;
    end else begin : g_align
      assign sp_misaligned = use_sp && (sp_val[SP_ALIGN_LOG2-1:0] != '0);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cmpb_q <= '0;
      newb_q <= '0;
      rs_q   <= '0;
      acq_q  <= 1'b0;
      rel_q  <= 1'b0;
      tag_q  <= 1'b0;
      old_q  <= '0;
    end else begin
      if (cap_en) begin
        addr_q <= addr_d;
        cmpb_q <= cmp_val[BYTE_W-1:0];
        newb_q <= new_val[BYTE_W-1:0];
        rs_q   <= dec.rs;
        acq_q  <= dec.acq;
        rel_q  <= dec.rel;
        tag_q  <= dec.tagchk;
      end
      if (rd_en) begin
        old_q <= mem_rdata;
      end
    end
  end

  always_comb begin
    cmp_equal = (old_q == cmpb_q);
    mem_addr  = addr_q;
    mem_wdata = newb_q;
    wb_data   = {{PAD_W{1'b0}}, old_q};
    wb_idx    = rs_q;
    acq       = acq_q;
    rel       = rel_q;
    tagchk    = tag_q;
  end

  // R6: a compare miss never leads to a write
  a_r6_no_write_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CMP && !cmp_equal) |=> (state != ST_WRITE));

  // R5: the address does not move during an operation
  a_r5_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(mem_addr));
endmodule

// File: rtl/bcas_seq.sv
module bcas_seq
  import bcas_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        start_fault,
  input  logic        mem_ack,
  input  logic        mem_abort,
  input  logic        cmp_equal,
  output bcas_state_e state,
  output logic        mem_req,
  output logic        mem_we,
  output logic        mem_lock,
  output logic        wb_en,
  output logic        done,
  output logic        align_fault,
  output logic        abort_fault,
  output logic        busy
);
  bcas_state_e state_q;
  bcas_state_e state_d;
  logic        flt_align_q;
  logic        flt_align_d;
  logic        flt_abort_q;
  logic        flt_abort_d;
  logic        flt_en;

  always_comb begin
    state_d     = state_q;
    flt_align_d = flt_align_q;
    flt_abort_d = flt_abort_q;
    flt_en      = 1'b0;
    case (state_q)
      ST_IDLE: begin
        flt_en      = 1'b1;
        flt_align_d = start_fault && !start;
        flt_abort_d = 1'b0;
        if (start) begin
          state_d = ST_READ;
        end else if (start_fault) begin
          state_d = ST_FAULT;
        end
      end
      ST_READ: begin
        if (mem_ack) begin
          if (mem_abort) begin
            flt_en      = 1'b1;
            flt_abort_d = 1'b1;
            state_d     = ST_FAULT;
          end else begin
            state_d = ST_CMP;
          end
        end
      end
      ST_CMP: begin
        state_d = cmp_equal ? ST_WRITE : ST_WB;
      end
      ST_WRITE: begin
        if (mem_ack) begin
          if (mem_abort) begin
            flt_en      = 1'b1;
            flt_abort_d = 1'b1;
            state_d     = ST_FAULT;
          end else begin
            state_d = ST_WB;
          end
        end
      end
      ST_WB:    state_d = ST_IDLE;
      ST_FAULT: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      flt_align_q <= 1'b0;
      flt_abort_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (flt_en) begin
        flt_align_q <= flt_align_d;
        flt_abort_q <= flt_abort_d;
      end
    end
  end

  always_comb begin
    state       = state_q;
    mem_req     = (state_q == ST_READ) || (state_q == ST_WRITE);
    mem_we      = (state_q == ST_WRITE);
    mem_lock    = (state_q == ST_READ) || (state_q == ST_CMP) || (state_q == ST_WRITE);
    wb_en       = (state_q == ST_WB);
    done        = (state_q == ST_WB) || (state_q == ST_FAULT);
    align_fault = (state_q == ST_FAULT) && flt_align_q;
    abort_fault = (state_q == ST_FAULT) && flt_abort_q;
    busy        = (state_q != ST_IDLE);
  end

  // R7: every request is made under the lock
  a_r7_lock_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_lock);

  // R7: once taken, the lock stays until the operation finishes
  a_r7_lock_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_lock |=> (mem_lock || done));

  // R9: a fault never comes with a write-back
  a_r9_no_wb_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (align_fault || abort_fault) |-> !wb_en);

  // R4: an alignment fault comes straight from idle, with no access
  a_r4_align_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    align_fault |-> ($past(state_q) == ST_IDLE));

  // R11: done is a single pulse followed by idle
  a_r11_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !done));
endmodule

// File: rtl/bcas_unit.sv
module bcas_unit
  import bcas_pkg::*;
#(
  parameter int ADDR_W        = 64,
  parameter int REG_W         = 32,
  parameter int SP_ALIGN_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_valid,
  input  logic [31:0]       insn_word,
  input  logic [REG_W-1:0]  cmp_val,
  input  logic [REG_W-1:0]  new_val,
  input  logic [ADDR_W-1:0] base_val,
  input  logic [ADDR_W-1:0] sp_val,
  output logic              busy,
  output logic              done,
  output logic              undef_insn,
  output logic              align_fault,
  output logic              abort_fault,
  output logic              acq_order,
  output logic              rel_order,
  output logic              tag_check,
  output logic              reuse_hint,
  output logic              wb_en,
  output logic [4:0]        wb_idx,
  output logic [REG_W-1:0]  wb_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_lock,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_abort,
  input  logic [7:0]        mem_rdata
);
  logic        rst_s1_n;
  logic        rst_s2_n;
  bcas_dec_t   dec;
  bcas_state_e state;
  logic        accept;
  logic        cap_en;
  logic        start;
  logic        start_fault;
  logic        rd_en;
  logic        sp_misaligned;
  logic        cmp_equal;
  logic        undef_q;
  logic        hint_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_n <= 1'b0;
      rst_s2_n <= 1'b0;
    end else begin
      rst_s1_n <= 1'b1;
      rst_s2_n <= rst_s1_n;
    end
  end

  bcas_decode u_dec (
    .insn (insn_word),
    .dec  (dec)
  );

  always_comb begin
    accept      = insn_valid && (state == ST_IDLE);
    cap_en      = accept && dec.claim;
    start       = cap_en && !sp_misaligned;
    start_fault = cap_en && sp_misaligned;
    rd_en       = (state == ST_READ) && mem_ack && !mem_abort;
  end

  bcas_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_s2_n),
    .start       (start),
    .start_fault (start_fault),
    .mem_ack     (mem_ack),
    .mem_abort   (mem_abort),
    .cmp_equal   (cmp_equal),
    .state       (state),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_lock    (mem_lock),
    .wb_en       (wb_en),
    .done        (done),
    .align_fault (align_fault),
    .abort_fault (abort_fault),
    .busy        (busy)
  );

  bcas_datapath #(
    .ADDR_W        (ADDR_W),
    .REG_W         (REG_W),
    .SP_ALIGN_LOG2 (SP_ALIGN_LOG2)
  ) u_dp (
    .clk           (clk),
    .rst_n         (rst_s2_n),
    .cap_en        (cap_en),
    .rd_en         (rd_en),
    .state         (state),
    .dec           (dec),
    .cmp_val       (cmp_val),
    .new_val       (new_val),
    .base_val      (base_val),
    .sp_val        (sp_val),
    .mem_rdata     (mem_rdata),
    .sp_misaligned (sp_misaligned),
    .cmp_equal     (cmp_equal),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .wb_data       (wb_data),
    .wb_idx        (wb_idx),
    .acq           (acq_order),
    .rel           (rel_order),
    .tagchk        (tag_check)
  );

  always_ff @(posedge clk or negedge rst_s2_n) begin
    if (!rst_s2_n) begin
      undef_q <= 1'b0;
      hint_q  <= 1'b0;
    end else begin
      undef_q <= accept && !dec.claim;
      hint_q  <= cap_en && dec.hint;
    end
  end

  assign undef_insn = undef_q;
  assign reuse_hint = hint_q;

  // R1: an undefined word starts nothing
  a_r1_undef_idle: assert property (@(posedge clk) disable iff (!rst_s2_n)
    undef_insn |-> (!busy && !mem_req));

  // R10: the reuse hint is a single-cycle pulse
  a_r10_hint_pulse: assert property (@(posedge clk) disable iff (!rst_s2_n)
    reuse_hint |=> !reuse_hint);

  // R1: the undefined report is a single-cycle pulse
  a_r1_undef_pulse: assert property (@(posedge clk) disable iff (!rst_s2_n)
    undef_insn |=> !undef_insn);
endmodule

// File: tb/sim_bcas_unit.sv
module sim_bcas_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk;
  logic        rst_n;
  logic        insn_valid;
  logic [31:0] insn_word;
  logic [31:0] cmp_val;
  logic [31:0] new_val;
  logic [63:0] base_val;
  logic [63:0] sp_val;
  logic        busy, done, undef_insn, align_fault, abort_fault;
  logic        acq_order, rel_order, tag_check, reuse_hint, wb_en;
  logic [4:0]  wb_idx;
  logic [31:0] wb_data;
  logic        mem_req, mem_we, mem_lock;
  logic [63:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_ack, mem_abort;
  logic [7:0]  mem_rdata;

  // memory model
  logic [7:0]  mem_byte;
  logic [7:0]  mem_preset;
  logic        mem_load;
  logic        ab_rd, ab_wr;
  logic        ack_q;

  int checks;
  int fails;

  bcas_unit u0 (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_word(insn_word),
    .cmp_val(cmp_val), .new_val(new_val), .base_val(base_val), .sp_val(sp_val),
    .busy(busy), .done(done), .undef_insn(undef_insn), .align_fault(align_fault),
    .abort_fault(abort_fault), .acq_order(acq_order), .rel_order(rel_order),
    .tag_check(tag_check), .reuse_hint(reuse_hint), .wb_en(wb_en), .wb_idx(wb_idx),
    .wb_data(wb_data), .mem_req(mem_req), .mem_we(mem_we), .mem_lock(mem_lock),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_abort(mem_abort), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (mem_load) mem_byte <= mem_preset;
    else if (mem_req && mem_we && ack_q && !mem_abort) mem_byte <= mem_wdata;
    ack_q <= mem_req && !ack_q;
  end
  assign mem_ack   = ack_q;
  assign mem_abort = ack_q && (mem_we ? ab_wr : ab_rd);
  assign mem_rdata = mem_byte;

  typedef struct packed {
    logic        l;
    logic        o;
    logic [4:0]  rs;
    logic [4:0]  rn;
    logic [4:0]  rt;
    logic [31:0] xm;
    logic [31:0] cv;
    logic [31:0] nv;
    logic [63:0] bv;
    logic [63:0] sv;
    logic [7:0]  mv;
    logic        ar;
    logic        aw;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VT [NV] = '{
    '{1'b0,1'b0,5'd1, 5'd2, 5'd3, 32'h0,         32'h1234_565A,32'h0000_00C3,64'h8000,64'h0,   8'h5A,1'b0,1'b0},
    '{1'b1,1'b0,5'd6, 5'd7, 5'd4, 32'h0,         32'h0000_0011,32'h0000_0099,64'h8010,64'h0,   8'h22,1'b0,1'b0},
    '{1'b1,1'b1,5'd8, 5'd9, 5'd31,32'h0,         32'h0000_003C,32'h0000_0000,64'h8020,64'h0,   8'h3C,1'b0,1'b0},
    '{1'b0,1'b1,5'd10,5'd31,5'd11,32'h0,         32'h0000_0040,32'h0000_0041,64'hDEAD,64'h1000,8'h40,1'b0,1'b0},
    '{1'b0,1'b0,5'd12,5'd31,5'd13,32'h0,         32'h0000_0040,32'h0000_0041,64'h0,   64'h1008,8'h40,1'b0,1'b0},
    '{1'b1,1'b0,5'd14,5'd15,5'd16,32'h0,         32'h0000_0050,32'h0000_0051,64'h9000,64'h0,   8'h50,1'b1,1'b0},
    '{1'b0,1'b1,5'd17,5'd18,5'd19,32'h0,         32'h0000_0060,32'h0000_0061,64'h9100,64'h0,   8'h60,1'b0,1'b1},
    '{1'b0,1'b0,5'd1, 5'd2, 5'd3, 32'h0020_0000, 32'h0000_0001,32'h0000_0002,64'h100, 64'h0,   8'h01,1'b0,1'b0},
    '{1'b0,1'b0,5'd5, 5'd20,5'd5, 32'h0,         32'hFFFF_FF77,32'hFFFF_FF77,64'hA000,64'h0,   8'h77,1'b0,1'b0},
    '{1'b0,1'b1,5'd21,5'd22,5'd21,32'h0,         32'h0000_0010,32'h0000_0010,64'hA100,64'h0,   8'h33,1'b0,1'b0},
    '{1'b1,1'b0,5'd1, 5'd2, 5'd3, 32'h0000_0800, 32'h0000_0001,32'h0000_0002,64'h100, 64'h0,   8'h01,1'b0,1'b0},
    '{1'b0,1'b0,5'd1, 5'd2, 5'd3, 32'h4000_0000, 32'h0000_0001,32'h0000_0002,64'h100, 64'h0,   8'h01,1'b0,1'b0}
  };

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_word(input vec_t v);
    return {2'b00, 7'b0010001, v.l, 1'b1, v.rs, v.o, 5'b11111, v.rn, v.rt} ^ v.xm;
  endfunction

  task automatic run_vec(input vec_t v);
    logic [31:0] w;
    logic        claimed, misal, eq, exp_wr, exp_wb, exp_abort;
    logic [63:0] exp_addr;
    logic [7:0]  exp_mem;
    logic        saw_req, lock_bad, wr_seen, fin;
    logic [63:0] got_addr;
    logic        f_wb, f_al, f_ab;
    logic [4:0]  f_idx;
    logic [31:0] f_data;
    w = mk_word(v);
    claimed = (w[31:30] == 2'b00) && (w[29:23] == 7'b0010001) && w[21] && (w[14:10] == 5'b11111);
    @(negedge clk);
    mem_preset = v.mv; mem_load = 1'b1; ab_rd = v.ar; ab_wr = v.aw;
    @(negedge clk);
    mem_load = 1'b0;
    insn_word = w; cmp_val = v.cv; new_val = v.nv; base_val = v.bv; sp_val = v.sv;
    insn_valid = 1'b1;
    @(negedge clk);
    insn_valid = 1'b0;
    if (!claimed) begin
      chk(undef_insn == 1'b1, "R1 undef pulse", {63'd0, undef_insn}, 64'd1);
      chk(busy == 1'b0, "R1 not busy", {63'd0, busy}, 64'd0);
      saw_req = 1'b0;
      for (int c = 0; c < 4; c++) begin
        if (mem_req) saw_req = 1'b1;
        @(negedge clk);
      end
      chk(!saw_req, "R1 no memory request", {63'd0, saw_req}, 64'd0);
      return;
    end
    chk(busy == 1'b1, "R11 busy after accept", {63'd0, busy}, 64'd1);
    chk(acq_order == (v.l && v.rt != 5'd31), "R2 acquire flag", {63'd0, acq_order}, {63'd0, v.l && v.rt != 5'd31});
    chk(rel_order == v.o, "R2 release flag", {63'd0, rel_order}, {63'd0, v.o});
    chk(tag_check == (v.rn != 5'd31), "R3 tag flag", {63'd0, tag_check}, {63'd0, v.rn != 5'd31});
    chk(reuse_hint == (v.rs == v.rt && !v.o), "R10 reuse hint", {63'd0, reuse_hint}, {63'd0, v.rs == v.rt && !v.o});
    saw_req = 1'b0; lock_bad = 1'b0; wr_seen = 1'b0; fin = 1'b0; got_addr = '0;
    f_wb = 1'b0; f_al = 1'b0; f_ab = 1'b0; f_idx = '0; f_data = '0;
    for (int c = 0; c < 40; c++) begin
      if (mem_req) begin
        saw_req = 1'b1; got_addr = mem_addr;
        if (!mem_lock) lock_bad = 1'b1;
      end
      if (saw_req && !mem_lock && !done) lock_bad = 1'b1;
      if (mem_req && mem_we && mem_ack && !mem_abort) wr_seen = 1'b1;
      if (done) begin
        fin = 1'b1; f_wb = wb_en; f_al = align_fault; f_ab = abort_fault;
        f_idx = wb_idx; f_data = wb_data;
        break;
      end
      @(negedge clk);
    end
    chk(fin, "R11 done reached", {63'd0, fin}, 64'd1);
    @(negedge clk);
    chk(busy == 1'b0, "R11 idle after done", {63'd0, busy}, 64'd0);
    misal    = (v.rn == 5'd31) && (v.sv[3:0] != 4'd0);
    exp_addr = (v.rn == 5'd31) ? v.sv : v.bv;
    eq       = (v.mv == v.cv[7:0]);
    exp_mem  = v.mv; exp_wr = 1'b0; exp_wb = 1'b0; exp_abort = 1'b0;
    if (!misal) begin
      if (v.ar) exp_abort = 1'b1;
      else if (eq && v.aw) exp_abort = 1'b1;
      else begin
        exp_wb = 1'b1;
        if (eq) begin exp_wr = 1'b1; exp_mem = v.nv[7:0]; end
      end
    end
    chk(f_al == misal, "R4 alignment fault", {63'd0, f_al}, {63'd0, misal});
    if (misal) chk(!saw_req, "R4 no access on misalign", {63'd0, saw_req}, 64'd0);
    else chk(got_addr == exp_addr, "R3 address select", got_addr, exp_addr);
    chk(f_ab == exp_abort, "R9 abort fault", {63'd0, f_ab}, {63'd0, exp_abort});
    chk(f_wb == exp_wb, "R8 write-back strobe", {63'd0, f_wb}, {63'd0, exp_wb});
    if (exp_wb) begin
      chk(f_idx == v.rs, "R8 write-back index", {59'd0, f_idx}, {59'd0, v.rs});
      chk(f_data == {24'd0, v.mv}, "R8 write-back data", {32'd0, f_data}, {56'd0, v.mv});
    end
    chk(wr_seen == exp_wr, eq ? "R5 write on match" : "R6 no write on miss", {63'd0, wr_seen}, {63'd0, exp_wr});
    chk(mem_byte == exp_mem, "R5 memory byte", {56'd0, mem_byte}, {56'd0, exp_mem});
    chk(!lock_bad, "R7 lock coverage", {63'd0, lock_bad}, 64'd0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=done", WATCHDOG);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int dones;
    logic [4:0] first_idx;
    checks = 0; fails = 0;
    rst_n = 1'b0; insn_valid = 1'b0; insn_word = '0; cmp_val = '0; new_val = '0;
    base_val = '0; sp_val = '0; mem_load = 1'b0; mem_preset = '0; ab_rd = 1'b0; ab_wr = 1'b0;
    ack_q = 1'b0; mem_byte = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    chk(busy == 1'b0, "R11 reset busy", {63'd0, busy}, 64'd0);
    chk(mem_req == 1'b0 && mem_lock == 1'b0, "R7 reset bus idle", {62'd0, mem_req, mem_lock}, 64'd0);
    chk(done == 1'b0 && wb_en == 1'b0, "R8 reset no done", {62'd0, done, wb_en}, 64'd0);

    for (int i = 0; i < NV; i++) run_vec(VT[i]);

    // R11: a word held on insn_valid while busy is ignored
    @(negedge clk);
    mem_preset = 8'h5A; mem_load = 1'b1; ab_rd = 1'b0; ab_wr = 1'b0;
    @(negedge clk);
    mem_load = 1'b0;
    insn_word = mk_word(VT[0]); cmp_val = 32'h5A; new_val = 32'hC3; base_val = 64'h8000;
    insn_valid = 1'b1;
    @(negedge clk);
    insn_word = {2'b00, 7'b0010001, 1'b0, 1'b1, 5'd9, 1'b0, 5'b11111, 5'd2, 5'd3};
    cmp_val = 32'hC3; new_val = 32'h11;
    dones = 0; first_idx = '0;
    for (int c = 0; c < 30; c++) begin
      if (done) begin
        dones++;
        if (dones == 1) first_idx = wb_idx;
        insn_valid = 1'b0;
      end
      @(negedge clk);
    end
    insn_valid = 1'b0;
    chk(dones == 1, "R11 one completion while busy", dones, 1);
    chk(first_idx == 5'd1, "R11 first word kept", {59'd0, first_idx}, 64'd1);
    chk(mem_byte == 8'hC3, "R11 second word ignored", {56'd0, mem_byte}, 64'hC3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule